// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address for every beat of a short burst in a synchronous memory pipeline. When a new access starts, it captures the whole external address. On each continue cycle it moves to the next beat. Only the low offset bits change from beat to beat. The bits above them keep the value captured at the start of the burst.

Two beat orders are available. The linear order adds the beat number to the starting offset and wraps modulo the burst length. The interleaved order XORs the beat number into the starting offset. The order select is meant to be strapped high or low at board level. Any of the starting offsets is legal. After the last beat, the sequence returns to its starting offset. An active-low clock enable freezes the sequencer completely.

The block keeps two registers: the captured start address and a beat count. The output address is formed from these through one add or XOR stage. The burst length defaults to four beats and must be a power of two.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, with no command applied, `addr_out` is all zeros.
- R2: A cycle with `cke_n`=0 and `adv_ld_n`=0 is a load. From the next cycle, `addr_out` equals the `addr_in` sampled at that edge, in either order mode.
- R3: A cycle with `cke_n`=0 and `adv_ld_n`=1 is an advance. It leaves every bit of `addr_out` above bit 1 unchanged.
- R4: With `order_sel`=0 (linear), after k advances the low two bits equal (start + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_sel`=1 (interleaved), after k advances the low two bits equal start XOR (k mod 4). For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R6: The fourth advance after a load returns `addr_out` to the loaded address, and the sequence then repeats.
- R7: While `cke_n`=1, `addr_out` holds its value whatever `adv_ld_n` and `addr_in` do. The burst resumes at the following beat once `cke_n` returns to 0.
- R8: A load in the middle of a burst restarts the sequence at beat zero from the new address.
- R9: Every advance changes the low two bits of `addr_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes all state |
| adv_ld_n | input | 1 | Low: load a new address; high: advance one beat |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved (static strap) |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current beat |

## Verification
The hardest case to reach from the ports is a freeze that lands in the middle of a burst while the other inputs ask for a load. A faulty design would then either drop the stalled beat or accept the new address.

To create it, the stimulus loads an address and advances once. It then raises `cke_n` for several cycles with `adv_ld_n` low and a different `addr_in` applied. Finally it releases the enable and expects the very next beat of the original sequence.

The bench also sweeps all four starting offsets in both orders, past the wrap point. This exposes off-by-one errors in the beat count and the wrong choice between add and XOR.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Beat order selected by the static strap input.
   typedef enum logic {
      ORDER_LINEAR = 1'b0,
      ORDER_XOR    = 1'b1
   } burst_order_e;

   // Per-cycle action decoded from the enable and strobe inputs.
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } burst_act_e;

   function automatic burst_act_e decode_act(input logic cke_n, input logic adv_ld_n);
      if (cke_n)          return ACT_HOLD;
      else if (!adv_ld_n) return ACT_LOAD;
      else                return ACT_STEP;
   endfunction

endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] start_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    start_q <= '0;
      else if (load) start_q <= addr_in;
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [CNT_W-1:0] beat_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // The count wraps naturally at 2**CNT_W, which closes the burst.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    beat_q <= '0;
      else if (clr)  beat_q <= '0;
      else if (step) beat_q <= beat_q + ONE;
   end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  burst_order_e     order,
   input  logic [CNT_W-1:0] start_lo,
   input  logic [CNT_W-1:0] beat,
   output logic [CNT_W-1:0] addr_lo
);

   logic [CNT_W-1:0] lin_lo;
   logic [CNT_W-1:0] xor_lo;

   // Linear order: modulo addition inside the offset field.
   assign lin_lo = start_lo + beat;

   // Interleaved order: each offset bit flips with its beat bit.
   for (genvar b = 0; b < CNT_W; b++) begin : g_xor_bit
      assign xor_lo[b] = start_lo[b] ^ beat[b];
   end

   generate
      if (CNT_W == 1) begin : g_single
         // With two beats both orders coincide.
         assign addr_lo = xor_lo;
      end else begin : g_multi
         assign addr_lo = (order == ORDER_XOR) ? xor_lo : lin_lo;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              adv_ld_n,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_len
         $error("burst_addr_gen: BURST_LEN must be a power of two of at least 2");
      end
      if (ADDR_W <= CNT_W) begin : g_bad_width
         $error("burst_addr_gen: ADDR_W must exceed the beat offset width");
      end
   endgenerate

   burst_act_e       act;
   burst_order_e     order;
   logic [ADDR_W-1:0] start_q;
   logic [CNT_W-1:0]  beat_q;
   logic [CNT_W-1:0]  addr_lo;

   assign act   = decode_act(cke_n, adv_ld_n);
   assign order = burst_order_e'(order_sel);

   burst_start_reg #(.ADDR_W(ADDR_W)) i_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (act == ACT_LOAD),
      .addr_in (addr_in),
      .start_q (start_q)
   );

   burst_beat_ctr #(.CNT_W(CNT_W)) i_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (act == ACT_LOAD),
      .step   (act == ACT_STEP),
      .beat_q (beat_q)
   );

   burst_order_map #(.CNT_W(CNT_W)) i_map (
      .order    (order),
      .start_lo (start_q[CNT_W-1:0]),
      .beat     (beat_q),
      .addr_lo  (addr_lo)
   );

   assign addr_out = {start_q[ADDR_W-1:CNT_W], addr_lo};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W    = 20,
   parameter int BURST_LEN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke_n,
   input logic              adv_ld_n,
   input logic              order_sel,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out
);

   localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv_ld_n) |=> (addr_out == $past(addr_in)));

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> (addr_out == $past(addr_out) || order_sel != $past(order_sel)));

   // R3
   upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && adv_ld_n) |=>
         (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

   // R4
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && adv_ld_n && !order_sel) |=>
         (order_sel || addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + CNT_W'(1)));

   // R9
   offset_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && adv_ld_n) |=>
         (addr_out[CNT_W-1:0] != $past(addr_out[CNT_W-1:0]) || order_sel != $past(order_sel)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke_n     (cke_n),
   .adv_ld_n  (adv_ld_n),
   .order_sel (order_sel),
   .addr_in   (addr_in),
   .addr_out  (addr_out)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke_n = 1'b0;
   logic          adv_ld_n = 1'b1;
   logic          order_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) i_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld_n(adv_ld_n),
      .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
   );

   task automatic check(input string req, input logic [AW-1:0] exp);
      checks++;
      if (addr_out !== exp) begin
         errors++;
         $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
      end
   endtask

   // One clock: inputs applied at the falling edge, result read at the next one.
   task automatic cyc(input logic ck, input logic adv, input logic [AW-1:0] a);
      cke_n = ck; adv_ld_n = adv; addr_in = a;
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] model(input logic [AW-1:0] s, input int k, input logic m);
      logic [1:0] lo;
      lo = m ? (s[1:0] ^ 2'(k)) : 2'(s[1:0] + 2'(k));
      return {s[AW-1:2], lo};
   endfunction

   task automatic t_reset();
      check("R1 during reset", '0);
      @(negedge clk); rst_n = 1'b1;
      cyc(1'b1, 1'b1, 20'hFFFFF);
      check("R1 after reset", '0);
   endtask

   task automatic t_sweep(input logic m);
      order_sel = m;
      for (int s = 0; s < 4; s++) begin
         logic [AW-1:0] st;
         st = {18'h2B5C3 + 18'(s * 7), 2'(s)};
         cyc(1'b0, 1'b0, st);
         check(m ? "R2 load xor" : "R2 load lin", st);
         for (int k = 1; k <= 6; k++) begin
            cyc(1'b0, 1'b1, ~st);
            if (k == 4) check("R6 wrap to start", st);
            else check(m ? "R5 interleaved beat" : "R4 linear beat", model(st, k, m));
         end
      end
   endtask

   task automatic t_literal();
      logic [1:0] lin01 [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
      logic [1:0] xr01  [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
      logic [1:0] xr10  [4] = '{2'b10, 2'b11, 2'b00, 2'b01};
      order_sel = 1'b0;
      cyc(1'b0, 1'b0, 20'h12341);
      for (int k = 0; k < 4; k++) begin
         check("R4 linear from 01", {18'h048D0, lin01[k]});
         cyc(1'b0, 1'b1, '0);
      end
      order_sel = 1'b1;
      cyc(1'b0, 1'b0, 20'h12341);
      for (int k = 0; k < 4; k++) begin
         check("R5 interleaved from 01", {18'h048D0, xr01[k]});
         cyc(1'b0, 1'b1, '0);
      end
      cyc(1'b0, 1'b0, 20'h12342);
      for (int k = 0; k < 4; k++) begin
         check("R5 interleaved from 10", {18'h048D0, xr10[k]});
         cyc(1'b0, 1'b1, '0);
      end
   endtask

   task automatic t_freeze();
      logic [AW-1:0] st = 20'hC0DE2;
      order_sel = 1'b0;
      cyc(1'b0, 1'b0, st);
      cyc(1'b0, 1'b1, '0);
      check("R7 beat before freeze", model(st, 1, 1'b0));
      for (int i = 0; i < 3; i++) begin
         cyc(1'b1, 1'b0, 20'h5A5A5);
         check("R7 frozen against load", model(st, 1, 1'b0));
      end
      cyc(1'b1, 1'b1, '0);
      check("R7 frozen against advance", model(st, 1, 1'b0));
      cyc(1'b0, 1'b1, '0);
      check("R7 resumes next beat", model(st, 2, 1'b0));
   endtask

   task automatic t_reload();
      logic [AW-1:0] a = 20'h70003;
      logic [AW-1:0] b = 20'h9ABC1;
      order_sel = 1'b1;
      cyc(1'b0, 1'b0, a);
      cyc(1'b0, 1'b1, '0);
      cyc(1'b0, 1'b1, '0);
      check("R8 mid burst", model(a, 2, 1'b1));
      cyc(1'b0, 1'b0, b);
      check("R8 reload start", b);
      cyc(1'b0, 1'b1, '0);
      check("R8 reload beat one", model(b, 1, 1'b1));
      check("R3 upper bits kept", {b[AW-1:2], addr_out[1:0]});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      finish_run();
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_sweep(1'b0);
      t_sweep(1'b1);
      t_literal();
      t_freeze();
      t_reload();
      finish_run();
   end

endmodule